// File: doc/BRIEF.md
# Board I/O Slave for a Data-Memory Bus

This block sits on a processor's data-memory bus as a slave and answers a small group of fixed high addresses. It does not handle ordinary RAM. A store to the display address keeps the low 16 bits of the write data and shows them as four hexadecimal digits on a seven-segment display. A store to the LED address keeps the low 10 bits and drives ten red LEDs. A load from the button address returns the four push-buttons, with a pressed button reading as 1. A load from the switch address returns a debounced copy of the ten slide switches, zero-extended to 32 bits.

Every address whose top nibble is 0xF belongs to the block's region and raises the hit signal. An address in that region that has no register reads as zero, and stores to it are ignored. Reads are combinational from the address. Stores take effect on the rising clock edge when the write enable is high.

Each switch bit has its own debouncer. The debouncer is a two-state machine:

- IDLE_MATCH: the synchronized input equals the held value. The machine moves to SETTLING (transition *mismatch_seen*) when the two differ.
- SETTLING: a counter runs. The machine returns to IDLE_MATCH in one of two ways:
  - *bounce_back*: the input returns to the held value, and the held value is unchanged.
  - *accept*: the input has differed for the full stable window, and the held value takes the new input.

Top module: `board_io_ctrl`

## Requirements
- R1: After reset the display register and the LED register are zero. Every digit shows the pattern for 0, and every LED is off.
- R2: A store to 0xF0000000 latches write data bits 15:0 as the display value. A load from 0xF0000000 returns that value zero-extended to 32 bits.
- R3: A store to 0xF0000004 latches write data bits 9:0 onto the LEDs, with led_o[i] taking data bit i. A load from 0xF0000004 returns that value zero-extended to 32 bits.
- R4: Digit k (k = 0..3) shows display bits 4k+3:4k on hex_seg_o[7k+6:7k]. Within each 7-bit group, bit 0 is segment a and bit 6 is segment g, and the segments are active low. The lit segments for each digit value are:
  - 0 = abcdef
  - 1 = bc
  - 2 = abdeg
  - 3 = abcdg
  - 4 = bcfg
  - 5 = acdfg
  - 6 = acdefg
  - 7 = abc
  - 8 = all seven segments
  - 9 = abcdfg
  - A = abcefg
  - b = cdefg
  - C = adef
  - d = bcdeg
  - E = adefg
  - F = aefg
- R5: A load from 0xF0000010 returns {28'b0, ~key_n_i} once the pins have been steady for 2 clock cycles. It reads 0 with no button pressed and 0xF with all four pressed.
- R6: A load from 0xF0000014 returns {22'b0, debounced switches}.
- R7: A debounced switch bit takes a new value only after its input has held that value for DEBOUNCE_CYCLES clock cycles, counted after the 2-flop synchronizer. A change shorter than that leaves the debounced bit unchanged.
- R8: bus_hit is 1 exactly when bus_addr[31:28] is 0xF. Loads with no hit, and loads from unassigned addresses in the region, return 0. Stores to unassigned addresses leave the display and the LEDs unchanged.
- R9: A bus cycle with bus_we low changes neither the display nor the LEDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_we | input | 1 | Store strobe |
| bus_rdata | output | 32 | Load data (combinational) |
| bus_hit | output | 1 | Address lies in the I/O region |
| key_n_i | input | 4 | Push-buttons, low when pressed |
| sw_i | input | 10 | Raw slide switches |
| hex_seg_o | output | 28 | Four digits of active-low segments |
| led_o | output | 10 | Red LEDs |

## Verification
The hardest case to reach is the bounce_back transition. The switch input must leave the held value long enough to enter SETTLING, then return before the window ends. The only visible result is that the switch readback does not change. The bench shrinks DEBOUNCE_CYCLES to 8 and applies a pulse of 5 cycles, followed by a long quiet period. It then applies a steady change and reads the switches at 8 cycles, which must still show the old value, and at 14 cycles, which must show the new value.

// File: rtl/board_io_pkg.sv
package board_io_pkg;
    localparam logic [31:0] ADDR_DISP = 32'hF000_0000;
    localparam logic [31:0] ADDR_LED  = 32'hF000_0004;
    localparam logic [31:0] ADDR_KEY  = 32'hF000_0010;
    localparam logic [31:0] ADDR_SW   = 32'hF000_0014;
    localparam logic [3:0]  REGION_TAG = 4'hF;

    typedef enum logic {
        IDLE_MATCH = 1'b0,
        SETTLING   = 1'b1
    } deb_state_t;
endpackage

// File: rtl/bio_debounce.sv
module bio_debounce #(
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    import board_io_pkg::*;

    localparam int CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    logic       sync1, sync2;
    logic [CW-1:0] cnt;
    deb_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw_i;
            sync2 <= sync1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE_MATCH: if (sync2 != clean_o) state_nx = SETTLING;
            SETTLING: begin
                if (sync2 == clean_o)  state_nx = IDLE_MATCH;
                else if (cnt == LAST)  state_nx = IDLE_MATCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE_MATCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            clean_o <= 1'b0;
        end else begin
            unique case (state)
                IDLE_MATCH: cnt <= '0;
                SETTLING: begin
                    if (sync2 != clean_o && cnt == LAST) clean_o <= sync2;
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    assert_clean_from_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(state) == SETTLING));
    assert_clean_takes_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> (clean_o == $past(sync2)));
endmodule

// File: rtl/bio_hex7.sv
module bio_hex7 (
    input  logic [3:0] nib_i,
    output logic [6:0] seg_n_o
);
    logic [6:0] lit;

    always_comb begin
        unique case (nib_i)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            4'hF: lit = 7'h71;
        endcase
        seg_n_o = ~lit;
    end

    always_comb begin
        assert_digit_not_dark_R4: assert (seg_n_o != 7'h7F);
    end
endmodule

// File: rtl/bio_regs.sv
module bio_regs #(
    parameter int DISP_W = 16,
    parameter int LED_W  = 10,
    parameter int KEY_W  = 4,
    parameter int SW_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              we_i,
    input  logic [KEY_W-1:0]  key_pressed_i,
    input  logic [SW_W-1:0]   sw_clean_i,
    output logic [31:0]       rdata_o,
    output logic              hit_o,
    output logic [DISP_W-1:0] disp_o,
    output logic [LED_W-1:0]  led_o
);
    import board_io_pkg::*;

    logic sel_disp, sel_led, sel_key, sel_sw;

    assign hit_o    = (addr_i[31:28] == REGION_TAG);
    assign sel_disp = (addr_i == ADDR_DISP);
    assign sel_led  = (addr_i == ADDR_LED);
    assign sel_key  = (addr_i == ADDR_KEY);
    assign sel_sw   = (addr_i == ADDR_SW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_o <= '0;
            led_o  <= '0;
        end else if (we_i) begin
            if (sel_disp) disp_o <= wdata_i[DISP_W-1:0];
            if (sel_led)  led_o  <= wdata_i[LED_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_disp)     rdata_o = 32'(disp_o);
        else if (sel_led) rdata_o = 32'(led_o);
        else if (sel_key) rdata_o = 32'(key_pressed_i);
        else if (sel_sw)  rdata_o = 32'(sw_clean_i);
    end

    assert_disp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_i) |-> $stable(disp_o));
    assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_i) |-> $stable(led_o));
    assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (rdata_o == 32'd0));
    assert_unmapped_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel_disp && !sel_led) |-> ($stable(disp_o) && $stable(led_o)));
endmodule

// File: rtl/board_io_ctrl.sv
module board_io_ctrl #(
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_we,
    output logic [31:0] bus_rdata,
    output logic        bus_hit,
    input  logic [3:0]  key_n_i,
    input  logic [9:0]  sw_i,
    output logic [27:0] hex_seg_o,
    output logic [9:0]  led_o
);
    localparam int DIGITS = 4;
    localparam int KEY_W  = 4;
    localparam int SW_W   = 10;
    localparam int DISP_W = DIGITS * 4;

    logic [KEY_W-1:0]  key_s1, key_s2;
    logic [SW_W-1:0]   sw_clean;
    logic [DISP_W-1:0] disp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_s1 <= '0;
            key_s2 <= '0;
        end else begin
            key_s1 <= ~key_n_i;
            key_s2 <= key_s1;
        end
    end

    for (genvar i = 0; i < SW_W; i++) begin : g_sw
        bio_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (sw_i[i]),
            .clean_o (sw_clean[i])
        );
    end

    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        bio_hex7 u_hex (
            .nib_i   (disp[4*d +: 4]),
            .seg_n_o (hex_seg_o[7*d +: 7])
        );
    end

    bio_regs #(
        .DISP_W(DISP_W), .LED_W(10), .KEY_W(KEY_W), .SW_W(SW_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (bus_addr),
        .wdata_i       (bus_wdata),
        .we_i          (bus_we),
        .key_pressed_i (key_s2),
        .sw_clean_i    (sw_clean),
        .rdata_o       (bus_rdata),
        .hit_o         (bus_hit),
        .disp_o        (disp),
        .led_o         (led_o)
    );
endmodule

// File: tb/board_io_ctrl_tb.sv
module board_io_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_hit;
    logic [3:0]  key_n_i = 4'hF;
    logic [9:0]  sw_i = '0;
    logic [27:0] hex_seg_o;
    logic [9:0]  led_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    board_io_ctrl #(.DEBOUNCE_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
        .key_n_i(key_n_i), .sw_i(sw_i), .hex_seg_o(hex_seg_o), .led_o(led_o)
    );

    function automatic logic [6:0] seg_of(input logic [3:0] n);
        logic [6:0] on;
        case (n)
            4'h0: on = 7'b0111111; 4'h1: on = 7'b0000110;
            4'h2: on = 7'b1011011; 4'h3: on = 7'b1001111;
            4'h4: on = 7'b1100110; 4'h5: on = 7'b1101101;
            4'h6: on = 7'b1111101; 4'h7: on = 7'b0000111;
            4'h8: on = 7'b1111111; 4'h9: on = 7'b1101111;
            4'hA: on = 7'b1110111; 4'hB: on = 7'b1111100;
            4'hC: on = 7'b0111001; 4'hD: on = 7'b1011110;
            4'hE: on = 7'b1111001; default: on = 7'b1110001;
        endcase
        return ~on;
    endfunction

    function automatic logic [27:0] segs_of(input logic [15:0] v);
        return {seg_of(v[15:12]), seg_of(v[11:8]), seg_of(v[7:4]), seg_of(v[3:0])};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic we);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        check("R1 segs", {4'h0, hex_seg_o}, {4'h0, segs_of(16'h0000)});
        check("R1 leds", {22'h0, led_o}, 32'h0);

        // R2/R4: every digit value in every digit position
        for (int n = 0; n < 16; n++) begin
            logic [15:0] v;
            v = {4{n[3:0]}};
            store(32'hF000_0000, {16'hDEAD, v}, 1'b1);
            check("R4 digits", {4'h0, hex_seg_o}, {4'h0, segs_of(v)});
        end
        store(32'hF000_0000, 32'hFFFF_1A3C, 1'b1);
        check("R4 mixed", {4'h0, hex_seg_o}, {4'h0, segs_of(16'h1A3C)});
        load(32'hF000_0000, r);
        check("R2 readback", r, 32'h0000_1A3C);

        // R3 walking LED bit
        for (int b = 0; b < 10; b++) begin
            store(32'hF000_0004, 32'hFFFF_FC00 | (32'h1 << b), 1'b1);
            check("R3 led", {22'h0, led_o}, 32'h1 << b);
        end
        store(32'hF000_0004, 32'hFFFF_FEB5, 1'b1);
        load(32'hF000_0004, r);
        check("R3 readback", r, 32'h0000_02B5);

        // R9 write enable low
        store(32'hF000_0000, 32'h0000_9999, 1'b0);
        store(32'hF000_0004, 32'h0000_0111, 1'b0);
        check("R9 disp", {4'h0, hex_seg_o}, {4'h0, segs_of(16'h1A3C)});
        check("R9 led", {22'h0, led_o}, 32'h2B5);

        // R8 unassigned region addresses and misses
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a;
            case (k)
                0: a = 32'hF000_0008; 1: a = 32'hF000_000C;
                2: a = 32'hF000_0018; 3: a = 32'hF000_0100;
                4: a = 32'hF800_0000; default: a = 32'hF000_0001;
            endcase
            store(a, 32'hFFFF_FFFF, 1'b1);
            load(a, r);
            check("R8 unassigned read", r, 32'h0);
            check("R8 hit", {31'h0, bus_hit}, 32'h1);
        end
        check("R8 disp kept", {4'h0, hex_seg_o}, {4'h0, segs_of(16'h1A3C)});
        check("R8 led kept", {22'h0, led_o}, 32'h2B5);
        load(32'h0000_0000, r);
        check("R8 miss read", r, 32'h0);
        check("R8 miss hit", {31'h0, bus_hit}, 32'h0);
        load(32'hE000_0000, r);
        check("R8 miss hit2", {31'h0, bus_hit}, 32'h0);

        // R5 all button combinations
        for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            key_n_i = ~m[3:0];
            wait_cyc(3);
            load(32'hF000_0010, r);
            check("R5 keys", r, {28'h0, m[3:0]});
        end
        key_n_i = 4'hF;

        // R6/R7 steady change, timed
        load(32'hF000_0014, r);
        check("R6 initial sw", r, 32'h0);
        sw_i = 10'h2A5;
        wait_cyc(8);
        #1 check("R7 before window", bus_rdata, 32'h0);
        wait_cyc(6);
        #1 check("R6 after window", bus_rdata, 32'h0000_02A5);

        // R7 short bounce ignored
        @(negedge clk);
        sw_i = 10'h15A;
        wait_cyc(5);
        sw_i = 10'h2A5;
        wait_cyc(20);
        #1 check("R7 bounce ignored", bus_rdata, 32'h0000_02A5);

        // R6 all-ones
        sw_i = 10'h3FF;
        wait_cyc(20);
        #1 check("R6 all ones", bus_rdata, 32'h0000_03FF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule